// File: doc/BRIEF.md
# Four-Stage Shift Register with J/K-bar Serial Entry

This block is a small storage chain of four single-bit stages. On each rising clock edge it either captures a parallel word into all stages at once, or moves the contents one place along the chain from the first stage toward the last. In shift mode the first stage is not fed by a plain data bit. It is driven by a J input and an inverted-K input, so that on an edge it can keep its value, go to 0, go to 1 or flip, while the other stages move along.

An active-low clear empties every stage at once, without waiting for a clock edge, and wins over every other input. The last stage is also presented in complemented form. When J and the inverted-K input are tied together, the first stage acts as a plain serial data input. The clear asserts asynchronously and is expected to be released in step with the clock. The block has one clock domain and no internal synchronizer.

Top module: `shjk_register`

## Requirements
- R1: Stage contents change only on the low-to-high transition of `clk`, apart from clearing.
- R2: While `clr_n` is 0, every bit of `q` reads 0 at once, independent of the clock. A rising edge that occurs while `clr_n` is 0 loads nothing and shifts nothing.
- R3: With `shift_en` = 0 at a rising edge, `q` takes `par_in`, where bit 0 is the first stage and bit 3 the last. `jin` and `kin_n` have no effect on that edge.
- R4: With `shift_en` = 1 at a rising edge, `q[i]` takes the previous `q[i-1]` for i = 1 to 3.
- R5: With `shift_en` = 1 at a rising edge, the new `q[0]` is set by {`jin`,`kin_n`}: 01 keeps it, 00 makes it 0, 11 makes it 1, 10 inverts it.
- R6: `q_last_n` always equals the complement of `q[3]`.
- R7: Between rising edges, with `clr_n` at 1, input changes leave `q` unchanged.
- R8: With `jin` equal to `kin_n` in shift mode, the new `q[0]` equals `jin`.
- R9: After clear and before any clock edge, `q` is 0000 and `q_last_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low asynchronous clear |
| shift_en | input | 1 | 1 = shift toward the last stage, 0 = parallel load |
| jin | input | 1 | J input of the first stage |
| kin_n | input | 1 | Inverted K input of the first stage |
| par_in | input | 4 | Parallel load data; bit 0 feeds the first stage |
| q | output | 4 | Stage outputs; bit 0 is the first stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The hardest cases to reach are toggle mode run over several edges in a row and a clear that is held across a clock edge while a load is pending. An edge that only loads or shifts once cannot tell a correct toggle from a one-shot set or clear. It also cannot show whether clear really wins over a clock edge. The stimulus therefore holds J=1 with inverted-K=0 for several shifts from a known first-stage value. It also lowers clear halfway through a cycle and keeps it low across an edge while a nonzero parallel word is presented in load mode.

// File: rtl/shjk_pkg.sv
package shjk_pkg;
  typedef enum logic [1:0] {
    JK_HOLD   = 2'd0,
    JK_CLEAR  = 2'd1,
    JK_SET    = 2'd2,
    JK_TOGGLE = 2'd3
  } jk_op_e;

  // Decode the J / inverted-K pair into a first-stage operation.
  function automatic jk_op_e jk_decode(input logic j, input logic k_n);
    case ({j, k_n})
      2'b01:   return JK_HOLD;
      2'b00:   return JK_CLEAR;
      2'b11:   return JK_SET;
      default: return JK_TOGGLE;
    endcase
  endfunction

  // Next value of the first stage for a given operation.
  function automatic logic jk_apply(input jk_op_e op, input logic cur);
    case (op)
      JK_HOLD:  return cur;
      JK_CLEAR: return 1'b0;
      JK_SET:   return 1'b1;
      default:  return ~cur;
    endcase
  endfunction
endpackage

// File: rtl/shjk_head.sv
module shjk_head
  import shjk_pkg::*;
(
  input  logic clk,
  input  logic clr_n,
  input  logic shift_en,
  input  logic j,
  input  logic k_n,
  input  logic par_bit,
  output logic q
);
  jk_op_e op;
  logic   jk_next;
  logic   d_next;

  assign op      = jk_decode(j, k_n);
  assign jk_next = jk_apply(op, q);
  assign d_next  = shift_en ? jk_next : par_bit;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= d_next;
  end

  // R5
  jk_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !j && k_n) |=> (q == $past(q)));
  // R5
  jk_clear_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && !j && !k_n) |=> (q == 1'b0));
  // R5
  jk_set_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && j && k_n) |=> (q == 1'b1));
  // R5
  jk_toggle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    (shift_en && j && !k_n) |=> (q != $past(q)));
endmodule

// File: rtl/shjk_cell.sv
module shjk_cell (
  input  logic clk,
  input  logic clr_n,
  input  logic shift_en,
  input  logic ser_in,
  input  logic par_bit,
  output logic q
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)        q <= 1'b0;
    else if (shift_en) q <= ser_in;
    else               q <= par_bit;
  end
endmodule

// File: rtl/shjk_register.sv
module shjk_register #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              shift_en,
  input  logic              jin,
  input  logic              kin_n,
  input  logic [STAGES-1:0] par_in,
  output logic [STAGES-1:0] q,
  output logic              q_last_n
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] stage_q;

  shjk_head u_head (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .j        (jin),
    .k_n      (kin_n),
    .par_bit  (par_in[0]),
    .q        (stage_q[0])
  );

  for (genvar i = 1; i < STAGES; i++) begin : g_cell
    shjk_cell u_cell (
      .clk      (clk),
      .clr_n    (clr_n),
      .shift_en (shift_en),
      .ser_in   (stage_q[i-1]),
      .par_bit  (par_in[i]),
      .q        (stage_q[i])
    );
  end

  assign q        = stage_q;
  assign q_last_n = ~stage_q[LAST];

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !shift_en |=> (q == $past(par_in)));
  // R4
  shift_chk: assert property (@(posedge clk) disable iff (!clr_n)
    shift_en |=> (q[LAST:1] == $past(q[LAST-1:0])));
  // R2
  clear_chk: assert property (@(posedge clk)
    !clr_n |-> (q == '0));
endmodule

// File: tb/test_shjk_register.sv
module test_shjk_register;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       shift_en = 1'b0;
  logic       jin = 1'b0;
  logic       kin_n = 1'b0;
  logic [3:0] par_in = 4'h0;
  logic [3:0] q;
  logic       q_last_n;

  int n_checks = 0;
  int n_fail = 0;
  int mdl[4];
  string last_tag = "R9";

  shjk_register i_shjk_register (
    .clk(clk), .clr_n(clr_n), .shift_en(shift_en), .jin(jin),
    .kin_n(kin_n), .par_in(par_in), .q(q), .q_last_n(q_last_n)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      foreach (mdl[i]) mdl[i] = 0;
      last_tag = "R2";
    end else if (!shift_en) begin
      for (int i = 0; i < 4; i++) mdl[i] = par_in[i];
      last_tag = "R3";
    end else begin
      for (int i = 3; i > 0; i--) mdl[i] = mdl[i-1];
      if (!jin && kin_n)       mdl[0] = mdl[0];
      else if (!jin && !kin_n) mdl[0] = 0;
      else if (jin && kin_n)   mdl[0] = 1;
      else                     mdl[0] = 1 - mdl[0];
      last_tag = (jin == kin_n) ? "R8 R5 R4" : "R5 R4";
    end
  end

  function automatic logic [3:0] mdl_word();
    logic [3:0] w;
    for (int i = 0; i < 4; i++) w[i] = (mdl[i] != 0);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, q, mdl_word());
    chk("R6", {3'b000, q_last_n}, {3'b000, ~mdl_word()[3]});
  endtask

  // One cycle: drive at negedge, check before next edge, then after it.
  task automatic cyc(input logic s, input logic j, input logic kn, input logic [3:0] p);
    @(negedge clk);
    shift_en = s; jin = j; kin_n = kn; par_in = p;
    #4;
    chk_all("R7 R1");
    @(negedge clk);
    chk_all(last_tag);
  endtask

  initial begin : watchdog
    #100us;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #3;
    chk("R9", q, 4'b0000);
    chk("R9", {3'b000, q_last_n}, 4'b0001);
    @(negedge clk); @(negedge clk);
    clr_n = 1'b1;
    chk_all("R9");
    // R3: loads, J/K set to values that would change the first stage
    cyc(1'b0, 1'b1, 1'b0, 4'b1010);
    cyc(1'b0, 1'b1, 1'b1, 4'b0101);
    cyc(1'b0, 1'b0, 1'b0, 4'b1111);
    cyc(1'b0, 1'b1, 1'b0, 4'b0001);
    // R4/R5: each J/K combination
    cyc(1'b1, 1'b0, 1'b1, 4'b0000); // hold
    cyc(1'b1, 1'b0, 1'b0, 4'b1111); // clear
    cyc(1'b1, 1'b1, 1'b1, 4'b0000); // set
    cyc(1'b1, 1'b0, 1'b1, 4'b0000); // hold at 1
    // R5 toggle across several edges
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b1, 1'b0, 4'b1001);
    // R8: J tied to inverted-K as serial data
    cyc(1'b1, 1'b1, 1'b1, 4'b0000);
    cyc(1'b1, 1'b0, 1'b0, 4'b1111);
    cyc(1'b1, 1'b1, 1'b1, 4'b0000);
    cyc(1'b1, 1'b1, 1'b1, 4'b0000);
    cyc(1'b1, 1'b0, 1'b0, 4'b0000);
    // R2: clear in mid-cycle, held across an edge with a load pending
    cyc(1'b0, 1'b0, 1'b0, 4'b1111);
    @(negedge clk);
    shift_en = 1'b0; par_in = 4'b0110;
    #2;
    clr_n = 1'b0;
    #1;
    chk("R2", q, 4'b0000);
    chk("R2", {3'b000, q_last_n}, 4'b0001);
    @(negedge clk);
    chk("R2", q, 4'b0000);
    clr_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b1, 4'b1100);
    cyc(1'b1, 1'b1, 1'b0, 4'b0000);
    cyc(1'b1, 1'b1, 1'b0, 4'b0000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule